// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Status Flags

This block is a full-duplex, clocked synchronous serial port that moves 8-bit frames. It generates the serial clock itself from the system clock with a fixed divider, shifts transmit data out on one line and captures receive data from another. Data moves LSB first. Software, or a DMA engine, talks to it through a small register bus. That bus holds a control register, a status register, a transmit data register and a receive data register.

Three status flags pace the traffic. The transmit-empty flag tells software that the transmit data register can take a new byte. The receive-full flag tells it that a received byte is waiting. The overrun flag tells it that a byte was lost because the previous one had not been collected. While the overrun flag is set, the port stops all traffic in both directions. Each time transmit-empty or receive-full rises, a one-cycle interrupt request pulse is issued. DMA-qualified accesses to the data registers clear the matching flag on their own.

The register bus has no wait states and no back-pressure: every read or write strobe completes in the cycle it is presented. Flow control is left entirely to the flags. A producer must wait for transmit-empty before writing, and a consumer must collect the byte while receive-full is set and before the next frame ends.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x80 (only transmit-empty set), the serial clock and the transmit line are high, and both interrupt pulses are low.
- R2: Register addresses: 0 is control (bit 0 transmit enable, bit 1 receive enable); 1 is status (bit 7 transmit-empty, bit 6 receive-full, bit 5 overrun); 2 is transmit data; 3 is receive data. Unused bits read 0.
- R3: Writing 0 to a status flag clears it only if a status read since the last status write returned that flag as 1. Writing 1 to a flag never changes it.
- R4: A frame is 8 bits, LSB first. The transmit line changes on falling serial clock edges and the receive line is sampled on rising edges. Each clock phase lasts CLK_DIV/2 system cycles, and the serial clock idles high.
- R5: With transmit enabled, the port idle and no overrun, a cleared transmit-empty flag starts a frame. Transmit-empty returns to 1 when the byte moves into the shifter, and irq_tx pulses for one cycle on every 0-to-1 change of transmit-empty.
- R6: If the next byte is handed over before the current frame ends, the next frame's first falling clock edge comes CLK_DIV/2+1 cycles after the previous frame's last rising edge. Otherwise the clock and the transmit line stay high.
- R7: A frame that ends with receive enabled and receive-full at 0 places the received byte in the receive data register, sets receive-full and pulses irq_rx for one cycle.
- R8: A frame that ends with receive enabled and receive-full still at 1 sets overrun and leaves the receive data register unchanged.
- R9: While overrun is 1, no frame starts in any mode. Traffic resumes after overrun is cleared.
- R10: A DMA-qualified write to the transmit data register clears transmit-empty, and a DMA-qualified read of the receive data register clears receive-full, with no prior status read.
- R11: An enable bit can be set only by a write made while both enables are 0. A write that tries to set a bit at any other time leaves that bit unchanged, while clearing always takes effect.
- R12: In transmit-only and full-duplex modes, a frame runs only when a byte has been handed over; full-duplex also captures a received byte. In receive-only mode, frames run back to back until overrun.
- R13: With transmit disabled the transmit line is held high; with receive disabled frames never set receive-full or overrun; clearing an enable stops an active frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_dma | input | 1 | Marks the current access as a DMA transfer |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_tx | output | 1 | One-cycle pulse when transmit-empty rises |
| irq_rx | output | 1 | One-cycle pulse when receive-full rises |
| sclk | output | 1 | Serial clock, idles high |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The assertions assume that read and write strobes are never presented together and that the DMA qualifier accompanies only data register accesses. They also assume that rxd is settled at every rising serial clock edge and that status flags are cleared only outside the cycle in which a frame ends. The bench drives the bus only at falling system clock edges, one access at a time. A serial peer model changes rxd only on falling serial clock edges, and the bench hands over or collects bytes well inside a frame rather than at its last cycle.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TXD  = 2'd2,
    REG_RXD  = 2'd3
  } reg_sel_e;

  localparam int STAT_TXE = 7;
  localparam int STAT_RXF = 6;
  localparam int STAT_OVR = 5;

  localparam int MODE_TX = 0;
  localparam int MODE_RX = 1;
endpackage

// File: rtl/ssx_mode_ctrl.sv
module ssx_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_wdata,
  output logic [1:0] mode,
  output logic       halt
);
  logic [1:0] mode_nxt;

  // A bit may rise only when the port is fully stopped; clearing is always honoured.
  always_comb begin
    if (mode == 2'b00) mode_nxt = ctrl_wdata;
    else               mode_nxt = mode & ctrl_wdata;
    halt = ctrl_wr && ((mode & ~ctrl_wdata) != 2'b00);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mode <= 2'b00;
    else if (ctrl_wr) mode <= mode_nxt;
  end

  // R11: no enable bit rises from a write issued while the port is running
  p_no_join_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && mode != 2'b00) |=> ((mode & ~$past(mode)) == 2'b00));
endmodule

// File: rtl/ssx_bit_engine.sv
module ssx_bit_engine #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              tx_on,
  input  logic              rx_on,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rxd,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sclk,
  output logic              txd
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int DIV_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic              active;
  logic [DIV_W-1:0]  div;
  logic [EDGE_W-1:0] edge_idx;
  logic [DATA_W-1:0] tsh;
  logic [DATA_W-1:0] rsh;
  logic              tick;
  logic              last_edge;

  assign tick      = active && (div == DIV_W'(HALF - 1));
  assign last_edge = (edge_idx == EDGE_W'(EDGES - 1));
  assign done      = tick && last_edge;
  assign busy      = active;
  assign rx_byte   = rsh;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      active   <= 1'b0;
      div      <= '0;
      edge_idx <= '0;
      tsh      <= '0;
      rsh      <= '0;
      sclk     <= 1'b1;
      txd      <= 1'b1;
    end else if (!active) begin
      if (start) begin
        active   <= 1'b1;
        div      <= '0;
        edge_idx <= '0;
        sclk     <= 1'b0;
        txd      <= tx_on ? tx_byte[0] : 1'b1;
        tsh      <= {1'b1, tx_byte[DATA_W-1:1]};
        rsh      <= '0;
      end
    end else if (tick) begin
      div <= '0;
      if (!edge_idx[0]) begin
        // rising edge: capture the receive line
        sclk     <= 1'b1;
        rsh      <= rx_on ? {rxd, rsh[DATA_W-1:1]} : '0;
        edge_idx <= edge_idx + 1'b1;
      end else if (last_edge) begin
        active   <= 1'b0;
        txd      <= 1'b1;
        edge_idx <= '0;
      end else begin
        // falling edge: present the next bit
        sclk     <= 1'b0;
        txd      <= tx_on ? tsh[0] : 1'b1;
        tsh      <= {1'b1, tsh[DATA_W-1:1]};
        edge_idx <= edge_idx + 1'b1;
      end
    end else begin
      div <= div + 1'b1;
    end
  end

  // R4: line and clock rest high between frames
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && txd));

  // R13: a disabled transmitter never drives a low bit
  p_tx_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |-> txd);

  generate
    if (HALF > 1) begin : g_phase_chk
      // R4: every clock phase inside a frame lasts more than one cycle
      p_phase_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $changed(sclk) && !abort) |=> $stable(sclk));
    end
  endgenerate
endmodule

// File: rtl/ssx_flags.sv
module ssx_flags
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_dma,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              rx_en,
  input  logic              tx_load,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              overrun,
  output logic              irq_tx,
  output logic              irq_rx
);
  logic stat_rd, stat_wr, txd_wr, dma_tx, dma_rx, rx_cap;
  logic arm_txe, arm_rxf, arm_ovr;
  logic clr_txe, clr_rxf, clr_ovr;
  logic txe_nxt, rxf_nxt, ovr_nxt;

  assign stat_rd = bus_rd && (bus_addr == REG_STAT);
  assign stat_wr = bus_wr && (bus_addr == REG_STAT);
  assign txd_wr  = bus_wr && (bus_addr == REG_TXD);
  assign dma_tx  = txd_wr && bus_dma;
  assign dma_rx  = bus_rd && bus_dma && (bus_addr == REG_RXD);
  assign rx_cap  = frame_done && rx_en;

  assign clr_txe = stat_wr && arm_txe && !bus_wdata[STAT_TXE];
  assign clr_rxf = stat_wr && arm_rxf && !bus_wdata[STAT_RXF];
  assign clr_ovr = stat_wr && arm_ovr && !bus_wdata[STAT_OVR];

  always_comb begin
    txe_nxt = tx_empty;
    if (tx_load)           txe_nxt = 1'b1;
    if (clr_txe || dma_tx) txe_nxt = 1'b0;

    rxf_nxt = rx_full;
    if (clr_rxf || dma_rx)   rxf_nxt = 1'b0;
    if (rx_cap && !rx_full)  rxf_nxt = 1'b1;

    ovr_nxt = overrun;
    if (clr_ovr)            ovr_nxt = 1'b0;
    if (rx_cap && rx_full)  ovr_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data  <= '0;
      rx_data  <= '0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      overrun  <= 1'b0;
      arm_txe  <= 1'b0;
      arm_rxf  <= 1'b0;
      arm_ovr  <= 1'b0;
      irq_tx   <= 1'b0;
      irq_rx   <= 1'b0;
    end else begin
      if (txd_wr) tx_data <= bus_wdata;
      if (rx_cap && !rx_full) rx_data <= rx_byte;
      tx_empty <= txe_nxt;
      rx_full  <= rxf_nxt;
      overrun  <= ovr_nxt;
      // a flag is armed for clearing by a read that saw it set; any status write consumes it
      arm_txe  <= txe_nxt && !stat_wr && (arm_txe || (stat_rd && tx_empty));
      arm_rxf  <= rxf_nxt && !stat_wr && (arm_rxf || (stat_rd && rx_full));
      arm_ovr  <= ovr_nxt && !stat_wr && (arm_ovr || (stat_rd && overrun));
      irq_tx   <= txe_nxt && !tx_empty;
      irq_rx   <= rxf_nxt && !rx_full;
    end
  end

  // R5: interrupt pulse accompanies each rise of transmit-empty, and only then
  p_irq_tx_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> irq_tx);
  p_irq_tx_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> $rose(tx_empty));

  // R7: receive interrupt pulse only on a rise of receive-full
  p_irq_rx_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> $rose(rx_full));

  // R8: a frame landing on a full buffer raises overrun and keeps the old byte
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cap && rx_full) |=> (overrun && $stable(rx_data)));

  // R10: DMA read of received data empties the buffer
  p_dma_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rx && rx_full) |=> !rx_full);

  // R3: writing ones leaves the flags alone
  p_write_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata[STAT_OVR] && !rx_cap) |=> $stable(overrun));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_dma,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              sclk,
  output logic              txd,
  input  logic              rxd
);
  logic [1:0]        mode;
  logic              halt;
  logic              ctrl_wr;
  logic              busy, frame_done, start, tx_load, can_go;
  logic              tx_empty, rx_full, overrun;
  logic [DATA_W-1:0] tx_data, rx_data, rx_byte;

  assign ctrl_wr = bus_wr && (bus_addr == REG_CTRL);

  ssx_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_wdata(bus_wdata[1:0]),
    .mode      (mode),
    .halt      (halt)
  );

  // frame launch: transmit modes wait for a handed-over byte, receive-only free-runs
  assign can_go  = !busy && !overrun && !halt;
  assign tx_load = can_go && mode[MODE_TX] && !tx_empty;
  assign start   = tx_load || (can_go && !mode[MODE_TX] && mode[MODE_RX]);

  ssx_bit_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .abort  (halt),
    .tx_on  (mode[MODE_TX]),
    .rx_on  (mode[MODE_RX]),
    .tx_byte(tx_data),
    .rxd    (rxd),
    .busy   (busy),
    .done   (frame_done),
    .rx_byte(rx_byte),
    .sclk   (sclk),
    .txd    (txd)
  );

  ssx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_dma   (bus_dma),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_en     (mode[MODE_RX]),
    .tx_load   (tx_load),
    .frame_done(frame_done),
    .rx_byte   (rx_byte),
    .tx_data   (tx_data),
    .rx_data   (rx_data),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full),
    .overrun   (overrun),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: bus_rdata[1:0] = mode;
      REG_STAT: begin
        bus_rdata[STAT_TXE] = tx_empty;
        bus_rdata[STAT_RXF] = rx_full;
        bus_rdata[STAT_OVR] = overrun;
      end
      REG_TXD:  bus_rdata = tx_data;
      default:  bus_rdata = rx_data;
    endcase
  end

  // R9: an idle port stays idle while overrun is pending
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !busy) |=> !busy);

  // R13: with both enables off no frame is in flight
  p_stopped_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !busy);
endmodule

// File: tb/sync_serial_xcvr_bench.sv
module sync_serial_xcvr_bench;
  localparam int DATA_W  = 8;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_dma = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_tx, irq_rx, sclk, txd;
  logic       rxd = 1'b1;

  sync_serial_xcvr #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_sync_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_dma(bus_dma),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .sclk(sclk), .txd(txd), .rxd(rxd)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int irq_tx_cnt = 0;
  int irq_rx_cnt = 0;
  logic [7:0] exp_q[$];
  logic [7:0] peer_q[$];
  logic tx_watch = 1'b0;
  int tx_bits = 0;
  int rx_bits = 0;
  logic [7:0] tx_sh = 8'd0;
  logic [7:0] peer_cur = 8'hFF;
  int last_rise_cyc = 0;
  int frame_gap = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && irq_tx) irq_tx_cnt++;
    if (rst_n && irq_rx) irq_rx_cnt++;
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: rebuild each transmitted byte from rising-edge samples
  always @(posedge sclk) begin
    if (rst_n) begin
      last_rise_cyc = cyc;
      tx_sh = {txd, tx_sh[7:1]};
      tx_bits++;
      if (tx_bits == 8) begin
        tx_bits = 0;
        if (tx_watch) begin
          if (exp_q.size() == 0) check_eq("R4 unexpected frame", tx_sh, 0);
          else check_eq("R4 transmitted byte", tx_sh, exp_q.pop_front());
        end
      end
    end
  end

  // serial peer: presents its byte LSB first on falling edges
  always @(negedge sclk) begin
    if (rst_n) begin
      if (rx_bits == 0) begin
        frame_gap = cyc - last_rise_cyc;
        peer_cur = (peer_q.size() != 0) ? peer_q.pop_front() : 8'hFF;
      end
      rxd = peer_cur[rx_bits];
      rx_bits = (rx_bits + 1) % 8;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic dma = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_dma = dma;
    @(negedge clk);
    bus_wr = 1'b0; bus_dma = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, input logic dma = 1'b0);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_dma = dma;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_dma = 1'b0;
  endtask

  // driver: queue the expected byte, then hand it over through the flag protocol
  task automatic send_byte(input logic [7:0] b);
    logic [7:0] s;
    exp_q.push_back(b);
    wr(2'd2, b);
    rd(2'd1, s);
    wr(2'd1, 8'h7F);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_high(input string tag, input int n);
    int lows = 0;
    repeat (n) begin
      @(negedge clk);
      if (!sclk || !txd) lows++;
    end
    check_eq(tag, lows, 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    idle(6);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R3 first, before any status read has armed a flag
    wr(2'd1, 8'h00);
    rd(2'd1, v); check_eq("R3 clear without read", v, 8'h80);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); check_eq("R3 write one no effect", v, 8'h80);
    // R1 reset state of the rest
    rd(2'd0, v); check_eq("R1 control reset", v, 8'h00);
    rd(2'd3, v); check_eq("R1 rx data reset", v, 8'h00);
    check_eq("R1 idle lines", {sclk, txd, irq_tx, irq_rx}, 4'b1100);
    wr(2'd1, 8'h7F);
    rd(2'd1, v); check_eq("R3 armed clear", v, 8'h00);

    // R5 / R11: pending byte 0x00 goes out as soon as transmit is enabled
    tx_watch = 1'b1;
    exp_q.push_back(8'h00);
    wr(2'd0, 8'h01);
    rd(2'd0, v); check_eq("R2 tx-only mode", v, 8'h01);
    wr(2'd0, 8'h03);
    rd(2'd0, v); check_eq("R11 late receive enable refused", v, 8'h01);
    drain();
    rd(2'd1, v); check_eq("R13 no receive flags while rx off", v, 8'h80);
    check_eq("R5 irq_tx count", irq_tx_cnt, 1);

    // R6 back-to-back frames
    send_byte(8'hA5);
    send_byte(8'h3C);
    drain();
    check_eq("R6 back-to-back gap", frame_gap, HALF + 1);
    check_eq("R5 irq_tx per hand-over", irq_tx_cnt, 3);
    hold_high("R6 line stops when nothing handed over", 40);

    // R11 full-duplex only from the stopped state
    wr(2'd0, 8'h00);
    rd(2'd0, v); check_eq("R11 clear enables", v, 8'h00);
    check_eq("R13 txd high when disabled", txd, 1);
    wr(2'd0, 8'h03);
    rd(2'd0, v); check_eq("R11 duplex entered", v, 8'h03);

    // R10 / R12 / R7 duplex with DMA hand-over
    peer_q.push_back(8'h96);
    exp_q.push_back(8'h5A);
    base = irq_rx_cnt;
    wr(2'd2, 8'h5A, 1'b1);
    while (irq_rx_cnt == base) @(negedge clk);
    drain();
    rd(2'd3, v); check_eq("R7 received byte", v, 8'h96);
    rd(2'd1, v); check_eq("R7 receive-full set", v, 8'hC0);
    rd(2'd3, v, 1'b1); check_eq("R10 dma read data", v, 8'h96);
    rd(2'd1, v); check_eq("R10 dma read clears receive-full", v, 8'h80);

    // R8 / R12 receive-only free-runs into overrun
    wr(2'd0, 8'h00);
    tx_watch = 1'b0;
    peer_q.push_back(8'h11);
    peer_q.push_back(8'h22);
    base = irq_rx_cnt;
    wr(2'd0, 8'h02);
    idle(100);
    hold_high("R9 receive frozen by overrun", 60);
    rd(2'd1, v); check_eq("R8 overrun flagged", v, 8'hE0);
    rd(2'd3, v); check_eq("R8 first byte kept", v, 8'h11);
    check_eq("R12 one receive interrupt", irq_rx_cnt - base, 1);

    // R9 transmit frozen until overrun cleared
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h01);
    tx_watch = 1'b1;
    send_byte(8'h69);
    hold_high("R9 transmit frozen by overrun", 60);
    rd(2'd1, v); check_eq("R9 flags while frozen", v, 8'h60);
    wr(2'd1, 8'hDF);
    drain();
    rd(2'd1, v); check_eq("R9 resumed after clear", v, 8'hC0);

    // R13 clearing the enable cuts a frame short
    tx_watch = 1'b0;
    wr(2'd2, 8'h00);
    rd(2'd1, v);
    wr(2'd1, 8'h7F);
    idle(10);
    check_eq("R13 frame running", sclk & txd, 0);
    wr(2'd0, 8'h00);
    hold_high("R13 abort leaves lines high", 40);

    summary();
    $finish;
  end
endmodule